// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block is the interrupt control word that sits beside a bank of countdown timers. Each channel has an enable bit and a sticky status bit in one register. When a channel's counter expires it sends a one-cycle pulse, and that pulse always sets the channel's status bit. The same pulse raises the channel's interrupt line only if the channel is enabled at that moment.

Software writes the enable field as a plain value. It clears pending status by writing ones to the status bits it has serviced. An interrupt line is level-held. It falls only when its status bit is cleared, so turning an enable off later does not withdraw an interrupt that was already raised. The full register value can be read at all times on the read port. Counting the timers is not part of this block.

Top module: `tic_irq_ctrl`

## Requirements
- R1: After reset every register bit reads 0 and every interrupt line is low.
- R2: A write replaces the enable bits, bits 4:0 of the read word (bit n belongs to channel n), with bits 4:0 of the write data from the next cycle on. Without a write the enable bits hold their value.
- R3: An expiry pulse on channel n sets status bit 5+n from the next cycle, whatever the state of enable bit n.
- R4: An expiry pulse on channel n raises interrupt line n in the next cycle when enable bit n is set. The enable value held before any write in that same cycle is the one that counts.
- R5: An expiry pulse on a channel whose enable bit is clear leaves that channel's interrupt line low.
- R6: Writing 1 to status bit 5+n clears it. Writing 0 there leaves it unchanged.
- R7: Interrupt line n falls in the cycle after status bit 5+n goes from 1 to 0. Clearing enable bit n does not lower it.
- R8: If an expiry on channel n and a write of 1 to status bit 5+n happen in the same cycle, the status bit stays set.
- R9: Bits 31:10 of the read word are always 0, and write data in those bits has no effect.
- R10: Setting an enable bit while its status bit is pending does not raise the interrupt line. Only an expiry raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expire_i | input | 5 | One-cycle expiry pulse per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register value |
| irq_o | output | 5 | Interrupt line per channel |

## Verification
The hardest cases to reach are the ones where two actions land in the same cycle: an expiry with a status clear, and an expiry with a write that changes the enable. A third is an interrupt line whose level no longer matches its enable bit. The bench reaches these by driving the expiry pulses and the write strobe in the same clock cycle. It sweeps every pair of enable pattern and expiry pattern, and after each pair it writes a clear mask together with the inverted enables. Directed sequences then disable a raised channel and enable a channel that is already pending, to show that the line stays put in both cases.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned TIC_NUM_CH = 5;
  localparam int unsigned TIC_DATA_W = 32;

  typedef enum logic {
    IRQ_LOW    = 1'b0,
    IRQ_RAISED = 1'b1
  } irq_state_e;
endpackage

// File: rtl/tic_en_reg.sv
module tic_en_reg #(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [NUM_CH-1:0] wr_bits_i,
  output logic [NUM_CH-1:0] en_o
);
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] en_d;
  logic              en_ce;

  always_comb begin
    en_ce = wr_en_i;
    en_d  = wr_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/tic_chan_cell.sv
module tic_chan_cell
  import tic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic en_i,
  input  logic clr_i,
  output logic status_o,
  output logic irq_o
);
  logic       status_q;
  logic       status_d;
  logic       status_fall;
  irq_state_e irq_q;
  irq_state_e irq_d;

  // Status: an expiry sets it and takes priority over a clear in the same cycle.
  always_comb begin
    status_d = status_q;
    if (expire_i) begin
      status_d = 1'b1;
    end else if (clr_i) begin
      status_d = 1'b0;
    end
    status_fall = status_q & ~status_d;
  end

  // Interrupt line: only an enabled expiry raises it, only a status fall lowers it.
  always_comb begin
    irq_d = irq_q;
    if (status_fall) begin
      irq_d = IRQ_LOW;
    end else if (expire_i && en_i) begin
      irq_d = IRQ_RAISED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= IRQ_LOW;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = (irq_q == IRQ_RAISED);
endmodule

// File: rtl/tic_rd_pack.sv
module tic_rd_pack #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] status_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned USED_W = 2 * NUM_CH;
  localparam int unsigned PAD_W  = DATA_W - USED_W;

  assign rd_data_o[NUM_CH-1:0]      = en_i;
  assign rd_data_o[USED_W-1:NUM_CH] = status_i;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data_o[DATA_W-1:USED_W] = '0;
    end
  endgenerate
endmodule

// File: rtl/tic_irq_ctrl.sv
module tic_irq_ctrl
  import tic_pkg::*;
#(
  parameter int unsigned NUM_CH = TIC_NUM_CH,
  parameter int unsigned DATA_W = TIC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned ST_LSB = NUM_CH;

  logic [NUM_CH-1:0] en;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] clr;

  assign clr = wr_en_i ? wr_data_i[ST_LSB +: NUM_CH] : '0;

  tic_en_reg #(.NUM_CH(NUM_CH)) i_en_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_bits_i (wr_data_i[NUM_CH-1:0]),
    .en_o      (en)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      tic_chan_cell i_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire_i[ch]),
        .en_i     (en[ch]),
        .clr_i    (clr[ch]),
        .status_o (status[ch]),
        .irq_o    (irq_o[ch])
      );
    end
  endgenerate

  tic_rd_pack #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_rd_pack (
    .en_i      (en),
    .status_i  (status),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/tic_irq_ctrl_chk.sv
module tic_irq_ctrl_chk #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] expire_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned ST_LSB = NUM_CH;
  localparam int unsigned USED_W = 2 * NUM_CH;

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[NUM_CH-1:0] == $past(wr_data_i[NUM_CH-1:0])); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o[NUM_CH-1:0])); // R2
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i != '0) |=> ((rd_data_o[ST_LSB +: NUM_CH] & $past(expire_i)) == $past(expire_i))); // R3
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((expire_i & rd_data_o[NUM_CH-1:0]) != '0) |=>
      ((irq_o & $past(expire_i & rd_data_o[NUM_CH-1:0])) == $past(expire_i & rd_data_o[NUM_CH-1:0]))); // R4
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~rd_data_o[ST_LSB +: NUM_CH]) == '0); // R7
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o)) & ~$past(expire_i & rd_data_o[NUM_CH-1:0])) == '0); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[DATA_W-1:USED_W] == '0); // R9
endmodule

bind tic_irq_ctrl tic_irq_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .expire_i  (expire_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o)
);

// File: tb/test_tic_irq_ctrl.sv
`timescale 1ns/1ps
module test_tic_irq_ctrl;
  logic        clk;
  logic        rst_n;
  logic [4:0]  expire;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [4:0]  irq;

  int n_checks;
  int n_fail;
  int cycles;
  bit done;

  tic_irq_ctrl i_tic_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs on a falling edge; outputs settle by the next falling edge.
  task automatic step(input logic [4:0] ex, input logic we, input logic [31:0] wd);
    @(negedge clk);
    expire  = ex;
    wr_en   = we;
    wr_data = wd;
    @(negedge clk);
    expire  = '0;
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 0;
    rst_n    = 1'b0;
    expire   = '0;
    wr_en    = 1'b0;
    wr_data  = '0;
    repeat (3) @(negedge clk);
    check("R1 read word", rd_data, 32'h0);
    check("R1 irq", {27'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 read after release", rd_data, 32'h0);

    // Sweep every enable pattern against every expiry pattern.
    for (int e = 0; e < 32; e++) begin
      for (int x = 0; x < 32; x++) begin
        logic [4:0] ev, xv, cv, e2;
        ev = e[4:0];
        xv = x[4:0];
        cv = xv ^ {ev[3:0], ev[4]};
        e2 = ~ev;
        step('0, 1'b1, {22'h0, 5'h1f, ev});
        check("R2 enable write", rd_data, {27'h0, ev});
        check("R7 irq low after clear", {27'h0, irq}, 32'h0);
        step(xv, 1'b0, '0);
        check("R3 status set", rd_data, {22'h0, xv, ev});
        check("R4 R5 irq on expiry", {27'h0, irq}, {27'h0, xv & ev});
        step('0, 1'b1, {22'h0, cv, e2});
        check("R6 status clear", rd_data, {22'h0, xv & ~cv, e2});
        check("R7 irq after clear", {27'h0, irq}, {27'h0, xv & ev & ~cv});
      end
    end

    // R7: clearing an enable leaves a raised line up.
    step('0, 1'b1, 32'h0000_03ff);
    step(5'b00100, 1'b0, '0);
    step('0, 1'b1, 32'h0);
    check("R7 disable keeps irq", {27'h0, irq}, 32'h4);
    check("R6 zero write keeps status", rd_data, 32'h0000_0080);
    step('0, 1'b1, 32'h0000_0080);
    check("R7 irq falls on clear", {27'h0, irq}, 32'h0);

    // R10: enabling a pending channel does not raise its line.
    step(5'b00010, 1'b0, '0);
    check("R5 disabled expiry", {27'h0, irq}, 32'h0);
    step('0, 1'b1, 32'h0000_0002);
    check("R10 enable on pending", {27'h0, irq}, 32'h0);
    check("R10 read word", rd_data, 32'h0000_0042);

    // R8: expiry and clear of the same bit together.
    step('0, 1'b1, 32'h0000_03ff);
    step(5'b01000, 1'b1, 32'h0000_010f);
    check("R8 set wins", rd_data, 32'h0000_010f);
    check("R8 irq raised", {27'h0, irq}, 32'h8);

    // R4: expiry uses the enable held before a same-cycle write.
    step('0, 1'b1, 32'h0000_03e1);
    step(5'b00001, 1'b1, 32'h0000_0000);
    check("R4 old enable", {27'h0, irq}, 32'h1);
    step('0, 1'b1, 32'h0000_03e0);
    step(5'b00001, 1'b1, 32'h0000_0001);
    check("R4 old enable clear", {27'h0, irq}, 32'h0);

    // R9: upper bits read zero and writes there have no effect.
    step('0, 1'b1, 32'h0000_03e0);
    step('0, 1'b1, 32'hffff_fc15);
    check("R9 upper ignored", rd_data, 32'h0000_0015);

    done = 1;
    finish_run();
  end
endmodule